// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access is allowed by a two-level page mapping. It receives the attribute bits of a directory entry and of a leaf entry, together with the kind of access (supervisor or user; read, write or instruction fetch) and two global controls: write-protect enable and no-execute enable. From these it produces a fault verdict, a five-bit fault error code, and the two entries with their accessed and dirty bits updated, ready to be written back.

A directory entry with its page-size bit set maps a large page. It is then the final level and the leaf input is ignored. Fetching the entries from memory, caching translations and raising the exception are all handled outside the block. Each request is marked by a one-cycle valid strobe. The verdict and the updated entries appear on registered outputs in the following cycle.

Top module: `pg_access_chk`

## Requirements
- R1: When inValid is sampled high, outValid is high after the next clock edge with that request's result. outValid is low in every other cycle, and reset clears outValid, fault, reqBad and errCode.
- R2: A present entry is malformed when bit 51 is set, or when bit 63 (no-execute) is set while nxEnable is 0. A malformed present entry at a level that is examined causes a fault and sets errCode bit 3.
- R3: The directory is examined first. If the directory entry has bit 0 clear, the access faults with errCode bit 0 cleared. The leaf entry is examined only when the directory is present and well-formed. A leaf with bit 0 clear also faults with errCode bit 0 cleared. In every other case errCode bit 0 is 1.
- R4: errCode bit 1 equals the write request, bit 2 equals the user request and bit 4 equals the fetch request. Bit 4 is forced to 0 whenever nxEnable is 0.
- R5: An access that writes through an examined entry with bit 1 clear faults only if wpEnable is 1 or the access is a user access. A supervisor write with wpEnable at 0 is allowed.
- R6: A user access faults when bit 2 is clear in the directory entry or in the examined leaf entry.
- R7: A fetch faults when bit 63 is set in the directory entry or in the examined leaf entry.
- R8: When directory bit 7 is set, leafEntryNew equals leafEntry and the leaf contents have no effect on the verdict. A successful access sets directory bit 5, and also directory bit 6 on a write.
- R9: A successful access to a normal page sets bit 5 in both entries. A write also sets leaf bit 6. All other bits pass through unchanged.
- R10: On a fault, dirEntryNew and leafEntryNew equal the inputs exactly.
- R11: A request with both accFetch and accWrite set is illegal. It gives reqBad=1, fault=0, errCode=0 and both entries unchanged. reqBad is 0 for any legal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| dirEntry | input | ENTRY_W | Directory-level entry |
| leafEntry | input | ENTRY_W | Leaf-level entry |
| accUser | input | 1 | Access comes from user mode |
| accWrite | input | 1 | Access is a write |
| accFetch | input | 1 | Access is an instruction fetch |
| wpEnable | input | 1 | Write protection also applies to supervisor writes |
| nxEnable | input | 1 | No-execute bit is honoured |
| outValid | output | 1 | Result strobe |
| fault | output | 1 | Access faults |
| reqBad | output | 1 | Illegal fetch-and-write request |
| errCode | output | 5 | Fault error code |
| dirEntryNew | output | ENTRY_W | Directory entry to write back |
| leafEntryNew | output | ENTRY_W | Leaf entry to write back |

## Verification
The hardest case to reach from the ports is a set of fault causes that combine: for example, a directory that is not present but also has bits 51 and 63 set, or a large page whose leaf input is itself malformed. In these cases only the order in which the levels are examined decides the error code. The bench therefore sweeps every combination of present, writable, user, no-execute and bit 51 at both levels, together with the page-size bit, all access kinds and both global controls. That is 65536 requests, issued back to back one per cycle. The accessed and dirty bits and the address bits are derived from the sweep index, so the pass-through of the address bits is also checked. Directed cases named by requirement come first.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;
  localparam int PG_PRES  = 0;
  localparam int PG_WR    = 1;
  localparam int PG_USR   = 2;
  localparam int PG_ACC   = 5;
  localparam int PG_DRT   = 6;
  localparam int PG_LARGE = 7;

  localparam int EC_W    = 5;
  localparam int EC_PRES = 0;
  localparam int EC_WR   = 1;
  localparam int EC_USR  = 2;
  localparam int EC_RSV  = 3;
  localparam int EC_EXE  = 4;

  localparam int LEVELS = 2;

  typedef struct packed {
    logic nx;
    logic rsvd;
    logic usr;
    logic wr;
    logic pres;
  } entryAttr_t;

  typedef struct packed {
    logic present;
    logic malformed;
    logic userDeny;
    logic writeDeny;
    logic execDeny;
  } lvlVerdict_t;

  typedef struct packed {
    logic fault;
    logic clrPresent;
    logic setRsvd;
    logic setDirA;
    logic setDirD;
    logic setLeafA;
    logic setLeafD;
    logic illegal;
  } chkStrobe_t;
endpackage

// File: rtl/pgchk_level.sv
module pgchk_level
  import pgchk_pkg::*;
(
  input  entryAttr_t  attr,
  input  logic        accUser,
  input  logic        accWrite,
  input  logic        accFetch,
  input  logic        wpEnable,
  input  logic        nxEnable,
  output lvlVerdict_t verdict
);
  always_comb begin
    verdict.present   = attr.pres;
    verdict.malformed = attr.rsvd | (attr.nx & ~nxEnable);
    verdict.userDeny  = accUser & ~attr.usr;
    verdict.writeDeny = accWrite & ~attr.wr & (wpEnable | accUser);
    verdict.execDeny  = accFetch & attr.nx;
  end
endmodule

// File: rtl/pgchk_ctrl.sv
module pgchk_ctrl
  import pgchk_pkg::*;
(
  input  entryAttr_t dirAttr,
  input  entryAttr_t leafAttr,
  input  logic       dirLarge,
  input  logic       accUser,
  input  logic       accWrite,
  input  logic       accFetch,
  input  logic       wpEnable,
  input  logic       nxEnable,
  output chkStrobe_t strobe
);
  entryAttr_t  lvlAttr [LEVELS];
  lvlVerdict_t lvlVerd [LEVELS];
  logic        lvlDeny [LEVELS];

  assign lvlAttr[0] = dirAttr;
  assign lvlAttr[1] = leafAttr;

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      pgchk_level u_level (
        .attr     (lvlAttr[g]),
        .accUser  (accUser),
        .accWrite (accWrite),
        .accFetch (accFetch),
        .wpEnable (wpEnable),
        .nxEnable (nxEnable),
        .verdict  (lvlVerd[g])
      );
      assign lvlDeny[g] = ~lvlVerd[g].present | lvlVerd[g].malformed |
                          lvlVerd[g].userDeny | lvlVerd[g].writeDeny |
                          lvlVerd[g].execDeny;
    end
  endgenerate

  logic illegal, dirUsable, leafChecked, anyFault;

  always_comb begin
    illegal     = accFetch & accWrite;
    dirUsable   = lvlVerd[0].present & ~lvlVerd[0].malformed;
    leafChecked = dirUsable & ~dirLarge;
    anyFault    = lvlDeny[0] | (leafChecked & lvlDeny[1]);

    strobe.illegal    = illegal;
    strobe.fault      = ~illegal & anyFault;
    strobe.clrPresent = ~illegal & (~lvlVerd[0].present |
                                    (leafChecked & ~lvlVerd[1].present));
    strobe.setRsvd    = ~illegal &
                        ((lvlVerd[0].present & lvlVerd[0].malformed) |
                         (leafChecked & lvlVerd[1].present & lvlVerd[1].malformed));
    strobe.setDirA    = ~illegal & ~anyFault;
    strobe.setDirD    = ~illegal & ~anyFault & dirLarge & accWrite;
    strobe.setLeafA   = ~illegal & ~anyFault & ~dirLarge;
    strobe.setLeafD   = ~illegal & ~anyFault & ~dirLarge & accWrite;
  end
endmodule

// File: rtl/pgchk_dpath.sv
module pgchk_dpath
  import pgchk_pkg::*;
#(
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  chkStrobe_t         strobe,
  input  logic [ENTRY_W-1:0] dirEntry,
  input  logic [ENTRY_W-1:0] leafEntry,
  input  logic               accUser,
  input  logic               accWrite,
  input  logic               accFetch,
  input  logic               nxEnable,
  output logic               outValid,
  output logic               fault,
  output logic               reqBad,
  output logic [EC_W-1:0]    errCode,
  output logic [ENTRY_W-1:0] dirEntryNew,
  output logic [ENTRY_W-1:0] leafEntryNew
);
  logic [EC_W-1:0]    errNext;
  logic [ENTRY_W-1:0] dirNext, leafNext;

  always_comb begin
    errNext = '0;
    if (!strobe.illegal) begin
      errNext[EC_PRES] = ~strobe.clrPresent;
      errNext[EC_WR]   = accWrite;
      errNext[EC_USR]  = accUser;
      errNext[EC_RSV]  = strobe.setRsvd;
      errNext[EC_EXE]  = accFetch & nxEnable;
    end
    dirNext  = dirEntry;
    leafNext = leafEntry;
    if (strobe.setDirA)  dirNext[PG_ACC]  = 1'b1;
    if (strobe.setDirD)  dirNext[PG_DRT]  = 1'b1;
    if (strobe.setLeafA) leafNext[PG_ACC] = 1'b1;
    if (strobe.setLeafD) leafNext[PG_DRT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      fault        <= 1'b0;
      reqBad       <= 1'b0;
      errCode      <= '0;
      dirEntryNew  <= '0;
      leafEntryNew <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        fault        <= strobe.fault;
        reqBad       <= strobe.illegal;
        errCode      <= errNext;
        dirEntryNew  <= dirNext;
        leafEntryNew <= leafNext;
      end
    end
  end
endmodule

// File: rtl/pg_access_chk.sv
module pg_access_chk
  import pgchk_pkg::*;
#(
  parameter int ENTRY_W  = 64,
  parameter int RSVD_BIT = 51
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [ENTRY_W-1:0] dirEntry,
  input  logic [ENTRY_W-1:0] leafEntry,
  input  logic               accUser,
  input  logic               accWrite,
  input  logic               accFetch,
  input  logic               wpEnable,
  input  logic               nxEnable,
  output logic               outValid,
  output logic               fault,
  output logic               reqBad,
  output logic [EC_W-1:0]    errCode,
  output logic [ENTRY_W-1:0] dirEntryNew,
  output logic [ENTRY_W-1:0] leafEntryNew
);
  localparam int NX_BIT = ENTRY_W - 1;

  entryAttr_t dirAttr, leafAttr;
  chkStrobe_t strobe;

  assign dirAttr  = '{nx: dirEntry[NX_BIT], rsvd: dirEntry[RSVD_BIT],
                      usr: dirEntry[PG_USR], wr: dirEntry[PG_WR],
                      pres: dirEntry[PG_PRES]};
  assign leafAttr = '{nx: leafEntry[NX_BIT], rsvd: leafEntry[RSVD_BIT],
                      usr: leafEntry[PG_USR], wr: leafEntry[PG_WR],
                      pres: leafEntry[PG_PRES]};

  pgchk_ctrl u_ctrl (
    .dirAttr  (dirAttr),
    .leafAttr (leafAttr),
    .dirLarge (dirEntry[PG_LARGE]),
    .accUser  (accUser),
    .accWrite (accWrite),
    .accFetch (accFetch),
    .wpEnable (wpEnable),
    .nxEnable (nxEnable),
    .strobe   (strobe)
  );

  pgchk_dpath #(.ENTRY_W(ENTRY_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .strobe       (strobe),
    .dirEntry     (dirEntry),
    .leafEntry    (leafEntry),
    .accUser      (accUser),
    .accWrite     (accWrite),
    .accFetch     (accFetch),
    .nxEnable     (nxEnable),
    .outValid     (outValid),
    .fault        (fault),
    .reqBad       (reqBad),
    .errCode      (errCode),
    .dirEntryNew  (dirEntryNew),
    .leafEntryNew (leafEntryNew)
  );
endmodule

// File: rtl/pgchk_sva.sv
module pgchk_sva
  import pgchk_pkg::*;
#(
  parameter int ENTRY_W = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [ENTRY_W-1:0] dirEntry,
  input logic [ENTRY_W-1:0] leafEntry,
  input logic               nxEnable,
  input logic               outValid,
  input logic               fault,
  input logic               reqBad,
  input logic [EC_W-1:0]    errCode,
  input logic [ENTRY_W-1:0] dirEntryNew,
  input logic [ENTRY_W-1:0] leafEntryNew
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_absent_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !reqBad && !$past(dirEntry[PG_PRES])) |-> (fault && !errCode[EC_PRES]));
  p_nxoff_fetch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(nxEnable)) |-> !errCode[EC_EXE]);
  p_large_leaf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(dirEntry[PG_LARGE])) |-> (leafEntryNew == $past(leafEntry)));
  p_success_acc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !fault && !reqBad) |-> dirEntryNew[PG_ACC]);
  p_fault_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fault) |-> (dirEntryNew == $past(dirEntry) && leafEntryNew == $past(leafEntry)));
  p_illegal_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && reqBad) |-> (!fault && errCode == '0));
endmodule

bind pg_access_chk pgchk_sva #(.ENTRY_W(ENTRY_W)) u_sva (.*);

// File: tb/pg_access_chk_test.sv
module pg_access_chk_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] dirEntry = '0, leafEntry = '0;
  logic        accUser = 1'b0, accWrite = 1'b0, accFetch = 1'b0;
  logic        wpEnable = 1'b0, nxEnable = 1'b0;
  logic        outValid, fault, reqBad;
  logic [4:0]  errCode;
  logic [63:0] dirEntryNew, leafEntryNew;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  pg_access_chk uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .dirEntry(dirEntry), .leafEntry(leafEntry),
    .accUser(accUser), .accWrite(accWrite), .accFetch(accFetch),
    .wpEnable(wpEnable), .nxEnable(nxEnable),
    .outValid(outValid), .fault(fault), .reqBad(reqBad), .errCode(errCode),
    .dirEntryNew(dirEntryNew), .leafEntryNew(leafEntryNew)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void refModel(input logic [63:0] d, input logic [63:0] l,
      input bit u, input bit w, input bit f, input bit wp, input bit nx,
      output bit flt, output logic [4:0] ec, output logic [63:0] dn,
      output logic [63:0] ln, output bit ill);
    bit dOk, lOk;
    ill = f & w;
    dn = d;
    ln = l;
    flt = 0;
    ec = '0;
    if (ill) return;
    ec = {f, 1'b0, u, w, 1'b1};
    dOk = d[0] && !d[51] && !(d[63] && !nx);
    if (!d[0]) begin flt = 1; ec[0] = 0; end
    else if (!dOk) begin flt = 1; ec[3] = 1; end
    if (u && !d[2]) flt = 1;
    if (w && !d[1] && (wp || u)) flt = 1;
    if (f && d[63]) flt = 1;
    if (dOk && !d[7]) begin
      lOk = l[0] && !l[51] && !(l[63] && !nx);
      if (!l[0]) begin flt = 1; ec[0] = 0; end
      else if (!lOk) begin flt = 1; ec[3] = 1; end
      if (u && !l[2]) flt = 1;
      if (w && !l[1] && (wp || u)) flt = 1;
      if (f && l[63]) flt = 1;
    end
    if (!nx) ec[4] = 0;
    if (!flt) begin
      dn[5] = 1;
      if (d[7]) begin
        if (w) dn[6] = 1;
      end else begin
        ln[5] = 1;
        if (w) ln[6] = 1;
      end
    end
  endfunction

  // one isolated request; outputs stable at the negedge after the capture edge
  task automatic runOne(input logic [63:0] d, input logic [63:0] l, input bit u,
                        input bit w, input bit f, input bit wp, input bit nx);
    @(negedge clk);
    dirEntry = d; leafEntry = l; accUser = u; accWrite = w; accFetch = f;
    wpEnable = wp; nxEnable = nx; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectRes(input string tag, input bit eFlt, input logic [4:0] eEc,
                           input logic [63:0] eDn, input logic [63:0] eLn);
    chk(outValid === 1'b1, {tag, " outValid"}, 64'(outValid), 64'd1);
    chk(fault === eFlt, {tag, " fault"}, 64'(fault), 64'(eFlt));
    chk(errCode === eEc, {tag, " errCode"}, 64'(errCode), 64'(eEc));
    chk(dirEntryNew === eDn, {tag, " dirEntryNew"}, dirEntryNew, eDn);
    chk(leafEntryNew === eLn, {tag, " leafEntryNew"}, leafEntryNew, eLn);
  endtask

  localparam logic [63:0] B51 = 64'h0008_0000_0000_0000;
  localparam logic [63:0] BNX = 64'h8000_0000_0000_0000;

  initial begin
    bit eF, eBad, pF, pBad, havePrev;
    logic [4:0] eEc, pEc;
    logic [63:0] eDn, eLn, pDn, pLn;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid === 1'b0 && fault === 1'b0 && reqBad === 1'b0 && errCode === 5'd0,
        "R1 reset", {outValid, fault, reqBad, errCode}, 64'd0);
    rstN = 1'b1;

    // R9: supervisor read of a normal page
    runOne(64'h7, 64'h7, 0, 0, 0, 0, 1);
    expectRes("R9 read", 0, 5'h01, 64'h27, 64'h27);
    @(negedge clk);
    chk(outValid === 1'b0, "R1 single pulse", 64'(outValid), 64'd0);
    // R9 / R4: user write sets leaf dirty
    runOne(64'h7, 64'h7, 1, 1, 0, 0, 1);
    expectRes("R9 R4 user write", 0, 5'h07, 64'h27, 64'h67);
    // R2: directory bit 51
    runOne(64'h7 | B51, 64'h7, 0, 0, 0, 0, 1);
    expectRes("R2 dir bit51", 1, 5'h09, 64'h7 | B51, 64'h7);
    // R2: leaf no-execute while disabled
    runOne(64'h7, 64'h7 | BNX, 0, 0, 0, 0, 0);
    expectRes("R2 leaf nx off", 1, 5'h09, 64'h7, 64'h7 | BNX);
    // R3: directory absent, leaf malformed must be ignored
    runOne(64'h6, 64'h7 | B51, 1, 0, 0, 0, 1);
    expectRes("R3 dir absent", 1, 5'h04, 64'h6, 64'h7 | B51);
    // R3: leaf absent
    runOne(64'h7, 64'h6, 0, 1, 0, 0, 1);
    expectRes("R3 leaf absent", 1, 5'h02, 64'h7, 64'h6);
    // R5: supervisor write to read-only leaf, protection off
    runOne(64'h7, 64'h5, 0, 1, 0, 0, 1);
    expectRes("R5 wp off", 0, 5'h03, 64'h27, 64'h65);
    // R5 / R10: protection on, entries stay unchanged
    runOne(64'h7, 64'h5, 0, 1, 0, 1, 1);
    expectRes("R5 R10 wp on", 1, 5'h03, 64'h7, 64'h5);
    // R5: user write to read-only, protection off
    runOne(64'h7, 64'h5, 1, 1, 0, 0, 1);
    expectRes("R5 user write", 1, 5'h07, 64'h7, 64'h5);
    // R6: user bit clear in directory, then in leaf
    runOne(64'h3, 64'h7, 1, 0, 0, 0, 1);
    expectRes("R6 dir", 1, 5'h05, 64'h3, 64'h7);
    runOne(64'h7, 64'h3, 1, 0, 0, 0, 1);
    expectRes("R6 leaf", 1, 5'h05, 64'h7, 64'h3);
    // R7: fetch from no-execute leaf
    runOne(64'h7, 64'h7 | BNX, 0, 0, 1, 0, 1);
    expectRes("R7 fetch nx", 1, 5'h11, 64'h7, 64'h7 | BNX);
    // R4: fetch with no-execute disabled hides the fetch bit
    runOne(64'h7, 64'h7, 0, 0, 1, 0, 0);
    expectRes("R4 fetch nx off", 0, 5'h01, 64'h27, 64'h27);
    // R8: large page write, malformed leaf ignored
    runOne(64'h87, B51, 0, 1, 0, 1, 1);
    expectRes("R8 large write", 0, 5'h03, 64'hE7, B51);
    // R11: illegal fetch with write
    runOne(64'h7, 64'h7, 1, 1, 1, 1, 1);
    expectRes("R11 illegal", 0, 5'h00, 64'h7, 64'h7);
    chk(reqBad === 1'b1, "R11 reqBad", 64'(reqBad), 64'd1);

    // exhaustive sweep, one request per cycle
    havePrev = 0;
    pF = 0; pBad = 0; pEc = '0; pDn = '0; pLn = '0;
    for (int i = 0; i < 65537; i++) begin
      @(negedge clk);
      if (havePrev) begin
        chk(outValid === 1'b1, "sweep R1 outValid", 64'(outValid), 64'd1);
        chk(fault === pF, "sweep fault", 64'(fault), 64'(pF));
        chk(reqBad === pBad, "sweep R11 reqBad", 64'(reqBad), 64'(pBad));
        chk(errCode === pEc, "sweep errCode", 64'(errCode), 64'(pEc));
        chk(dirEntryNew === pDn, "sweep dirEntryNew", dirEntryNew, pDn);
        chk(leafEntryNew === pLn, "sweep leafEntryNew", leafEntryNew, pLn);
      end
      if (i < 65536) begin
        logic [15:0] x;
        logic [63:0] d, l;
        x = 16'(i);
        l = '0; d = '0;
        l[0] = x[0]; l[1] = x[1]; l[2] = x[2]; l[63] = x[3]; l[51] = x[4];
        l[5] = x[0] ^ x[11]; l[6] = x[1] ^ x[13];
        l[39:12] = {12'hA5C, x};
        d[0] = x[5]; d[1] = x[6]; d[2] = x[7]; d[7] = x[8]; d[63] = x[9]; d[51] = x[10];
        d[5] = x[2] ^ x[12]; d[6] = x[3] ^ x[14];
        d[39:24] = ~x;
        dirEntry = d; leafEntry = l;
        accUser = x[11]; accWrite = x[12]; accFetch = x[13];
        wpEnable = x[14]; nxEnable = x[15]; inValid = 1'b1;
        refModel(d, l, x[11], x[12], x[13], x[14], x[15], eF, eEc, eDn, eLn, eBad);
        pF = eF; pEc = eEc; pDn = eDn; pLn = eLn; pBad = eBad;
        havePrev = 1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    chk(outValid === 1'b0, "R1 idle after sweep", 64'(outValid), 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule